// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-clock static memory with 64-bit words. Every address, data and control input is captured on the rising clock edge, and read data comes back through an output register one clock after the access is captured. An access sequence, called a burst, starts when either of two active-low address strobes is asserted while the chip enable is low. The strobe loads the external address. After that, an internal 2-bit counter produces up to three more addresses, stepping only on cycles where the advance input is low. The burst-order input picks linear order (low) or interleaved order (high).

The access type is decided each cycle from the write controls. A low global write stores every byte. Otherwise, a low byte-write gate lets the per-byte enables pick the bytes to store. If no byte is selected, the access is a read. A low output enable drives the shared data bus straight away, without waiting for the clock. A high sleep input stops all activity. After sleep is released, a configurable number of clock edges pass before accesses are accepted again. The depth is set by the address width; the default address width is 10 bits, and the block supports any width of 2 bits or more, up to 16 bits or beyond.

Top module: `burst_sram`

## Requirements
- R1: Read latency is fixed. A read captured at rising edge k places the addressed word on `dq` after edge k+1, and the output register holds that word until the next read is carried out.
- R2: At an edge where `ce_n` is low and either `strb_p_n` or `strb_c_n` is low, the address on `addr` is loaded, the burst counter is cleared, and that same address is accessed in the same cycle.
- R3: On a burst cycle with no strobe, the counter steps by one (modulo 4) when `adv_n` is low. When `adv_n` is high, the counter holds and the current address is accessed again.
- R4: When `burst_mode` is 0 (linear), the two low address bits are the loaded low bits plus the count, modulo 4. The upper address bits stay fixed for the whole burst.
- R5: When `burst_mode` is 1 (interleaved), the two low address bits are the loaded low bits XOR the count.
- R6: When `gwr_n` is high and `bwe_n` is low, byte i (bits 8i+7 down to 8i) is written if `bw_n[i]` is low. Bytes whose enable is high keep their old contents.
- R7: When `gwr_n` is low, all eight bytes are written, whatever `bwe_n` and `bw_n` are.
- R8: When `gwr_n` and `bwe_n` are both high, the access is a read and `bw_n` has no effect on memory.
- R9: `dq` is driven from the output register only while `oe_n` is low and `sleep` is low. At all other times it is high impedance. This follows the inputs without waiting for a clock edge.
- R10: At an edge where `sleep` is high, no access or burst change takes place. After `sleep` goes low, the next WAKE_CYCLES edges are also ignored.
- R11: A strobe with `ce_n` high ends the burst. Cycles with no strobe then perform no access until the next load.
- R12: After reset there is no active burst, no pending access, and the output register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state and output register |
| sleep | input | 1 | High puts the memory in power-down |
| burst_mode | input | 1 | 0 selects linear order, 1 selects interleaved order |
| ce_n | input | 1 | Active-low chip enable, sampled with a strobe |
| strb_p_n | input | 1 | Active-low processor-side address strobe |
| strb_c_n | input | 1 | Active-low controller-side address strobe |
| adv_n | input | 1 | Active-low burst advance |
| gwr_n | input | 1 | Active-low global write (all bytes) |
| bwe_n | input | 1 | Active-low gate for the per-byte enables |
| bw_n | input | DATA_W/8 | Active-low per-byte write enables |
| oe_n | input | 1 | Active-low asynchronous output enable |
| addr | input | ADDR_W | External word address |
| dq | inout | DATA_W | Shared data bus |

## Verification
The hardest condition to reach is the end of the wake-up window. Write attempts that arrive on the last ignored edges must be dropped, and the first edge after the window must be accepted. The stimulus holds `sleep` high across several write attempts. It then releases `sleep` and tries to write the same word on exactly WAKE_CYCLES consecutive edges. A read that follows shows whether any of those writes got through. Full counter wrap-around in both burst orders is reached by starting bursts at non-zero low bits and advancing three times.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   // low address bits of a burst: XOR walk or modulo-4 walk from the start
   function automatic logic [1:0] burst_low(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       interleave);
      return interleave ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/bsr_wake.sv
module bsr_wake #(
   parameter int WAKE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   output logic blocked
);
   localparam int CW = $clog2(WAKE_CYCLES + 1);

   logic [CW-1:0] wake_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wake_cnt <= '0;
      else if (sleep)
         wake_cnt <= CW'(WAKE_CYCLES);
      else if (wake_cnt != '0)
         wake_cnt <= wake_cnt - 1'b1;
   end

   assign blocked = sleep | (wake_cnt != '0);
endmodule

// File: rtl/bsr_addr_gen.sv
module bsr_addr_gen import burst_sram_pkg::*; #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ce_n,
   input  logic              strb_p_n,
   input  logic              strb_c_n,
   input  logic              adv_n,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              access,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              active,
   output logic [ADDR_W-1:0] base,
   output logic [1:0]        cnt
);
   logic       strobe, load, desel, step;
   logic [1:0] nxt_cnt;
   logic [ADDR_W-1:0] start;

   always_comb begin
      strobe  = ~strb_p_n | ~strb_c_n;
      load    = en & strobe & ~ce_n;
      desel   = en & strobe & ce_n;
      step    = en & active & ~strobe & ~adv_n;
      nxt_cnt = load ? 2'd0 : (step ? cnt + 2'd1 : cnt);
      start   = load ? addr_in : base;
      eff_addr = {start[ADDR_W-1:2], burst_low(start[1:0], nxt_cnt, interleave)};
      access  = load | (en & active & ~strobe);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base   <= '0;
         cnt    <= 2'd0;
         active <= 1'b0;
      end else if (load) begin
         base   <= addr_in;
         cnt    <= 2'd0;
         active <= 1'b1;
      end else if (desel) begin
         active <= 1'b0;
      end else if (step) begin
         cnt    <= cnt + 2'd1;
      end
   end
endmodule

// File: rtl/bsr_byte_ctl.sv
module bsr_byte_ctl #(
   parameter int NB = 8
) (
   input  logic          gwr_n,
   input  logic          bwe_n,
   input  logic [NB-1:0] bw_n,
   output logic [NB-1:0] be,
   output logic          is_wr
);
   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign be[g] = ~gwr_n | (~bwe_n & ~bw_n[g]);
   end

   assign is_wr = |be;
endmodule

// File: rtl/bsr_core.sv
module bsr_core import burst_sram_pkg::*; #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  op_e                 op,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   din,
   input  logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   q
);
   localparam int NB    = DATA_W / 8;
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (op == OP_WR) begin
         for (int b = 0; b < NB; b++) begin
            if (be[b]) mem[addr][8*b +: 8] <= din[8*b +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (op == OP_RD)
         q <= mem[addr];
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram import burst_sram_pkg::*; #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 64,
   parameter int WAKE_CYCLES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep,
   input  logic                burst_mode,
   input  logic                ce_n,
   input  logic                strb_p_n,
   input  logic                strb_c_n,
   input  logic                adv_n,
   input  logic                gwr_n,
   input  logic                bwe_n,
   input  logic [DATA_W/8-1:0] bw_n,
   input  logic                oe_n,
   input  logic [ADDR_W-1:0]   addr,
   inout  wire  [DATA_W-1:0]   dq
);
   localparam int NB = DATA_W / 8;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_chk_dw
      $error("burst_sram: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 2) begin : g_chk_aw
      $error("burst_sram: ADDR_W must be at least 2");
   end
   if (WAKE_CYCLES < 1) begin : g_chk_wake
      $error("burst_sram: WAKE_CYCLES must be at least 1");
   end

   logic              blocked, access, active, is_wr;
   logic [ADDR_W-1:0] eff_addr, burst_base;
   logic [1:0]        burst_cnt;
   logic [NB-1:0]     be;

   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;
   logic [NB-1:0]     be_q;
   logic [DATA_W-1:0] q;

   bsr_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .blocked(blocked)
   );

   bsr_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
      .clk(clk), .rst_n(rst_n), .en(~blocked), .ce_n(ce_n),
      .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
      .interleave(burst_mode), .addr_in(addr), .access(access),
      .eff_addr(eff_addr), .active(active), .base(burst_base), .cnt(burst_cnt)
   );

   bsr_byte_ctl #(.NB(NB)) u_bctl (
      .gwr_n(gwr_n), .bwe_n(bwe_n), .bw_n(bw_n), .be(be), .is_wr(is_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         din_q  <= '0;
         be_q   <= '0;
      end else begin
         op_q   <= access ? (is_wr ? OP_WR : OP_RD) : OP_IDLE;
         addr_q <= eff_addr;
         din_q  <= dq;
         be_q   <= be;
      end
   end

   bsr_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .op(op_q), .addr(addr_q),
      .din(din_q), .be(be_q), .q(q)
   );

   assign dq = (!oe_n && !sleep) ? q : 'z;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk import burst_sram_pkg::*; #(
   parameter int ADDR_W = 10,
   parameter int NB     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep,
   input logic              ce_n,
   input logic              strb_p_n,
   input logic              strb_c_n,
   input logic              adv_n,
   input logic              gwr_n,
   input logic              blocked,
   input logic              active,
   input logic [1:0]        burst_cnt,
   input logic [ADDR_W-1:0] burst_base,
   input op_e               op_q,
   input logic [NB-1:0]     be_q
);
   logic strobe;
   assign strobe = ~strb_p_n | ~strb_c_n;

   a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !ce_n && strobe) |=> (active && burst_cnt == 2'd0));

   a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked || !strobe || ce_n) |=> $stable(burst_base));

   a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !strobe && adv_n) |=> $stable(burst_cnt));

   a_r7_global_all: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && !gwr_n && !ce_n && strobe) |=> (op_q == OP_WR && (&be_q)));

   a_r10_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (op_q == OP_IDLE));

   a_r11_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked && ce_n && strobe) |=> !active);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .NB(DATA_W/8)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n),
   .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gwr_n(gwr_n),
   .blocked(blocked), .active(active), .burst_cnt(burst_cnt),
   .burst_base(burst_base), .op_q(op_q), .be_q(be_q)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
   localparam int AW   = 10;
   localparam int DW   = 64;
   localparam int WAKE = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic sleep, burst_mode, ce_n, strb_p_n, strb_c_n, adv_n, gwr_n, bwe_n, oe_n;
   logic [7:0]    bw_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] tb_dq;
   logic          tb_drv;
   wire  [DW-1:0] dq;

   assign dq = tb_drv ? tb_dq : 'z;

   burst_sram #(.ADDR_W(AW), .DATA_W(DW), .WAKE_CYCLES(WAKE)) u_burst_sram (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .burst_mode(burst_mode),
      .ce_n(ce_n), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
      .gwr_n(gwr_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
      .addr(addr), .dq(dq)
   );

   always #5 clk = ~clk;

   int    total = 0;
   int    bad   = 0;
   string cur_req = "R12";

   // behavioural reference state
   logic [DW-1:0] mem [int];
   logic [DW-1:0] exp_q = '0;
   int  m_active = 0, m_base = 0, m_cnt = 0, m_wake = 0;
   int  p_op = 0, p_addr = 0;
   logic [DW-1:0] p_din = '0;
   logic [7:0]    p_be = '0;

   task automatic edge_model();
      int acc, lo;
      bit blk;
      if (p_op == 2) begin
         if (!mem.exists(p_addr)) mem[p_addr] = '0;
         for (int b = 0; b < 8; b++)
            if (p_be[b]) mem[p_addr][8*b +: 8] = p_din[8*b +: 8];
      end else if (p_op == 1) begin
         exp_q = mem.exists(p_addr) ? mem[p_addr] : '0;
      end
      blk = sleep || (m_wake > 0);
      if (sleep) m_wake = WAKE;
      else if (m_wake > 0) m_wake--;
      p_op = 0;
      acc  = 0;
      if (!blk) begin
         if ((!strb_p_n || !strb_c_n) && !ce_n) begin
            m_base = int'(addr); m_cnt = 0; m_active = 1; acc = 1;
         end else if (!strb_p_n || !strb_c_n) begin
            m_active = 0;
         end else if (m_active != 0) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            acc = 1;
         end
         if (acc != 0) begin
            lo = burst_mode ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
            p_addr = (m_base & ~3) | lo;
            for (int b = 0; b < 8; b++) p_be[b] = !gwr_n || (!bwe_n && !bw_n[b]);
            p_op  = (p_be != 0) ? 2 : 1;
            p_din = tb_dq;
         end
      end
   endtask

   task automatic compare();
      logic [DW-1:0] e;
      if (tb_drv) return;
      e = (oe_n || sleep) ? {DW{1'bz}} : exp_q;
      total++;
      if (dq !== e) begin
         bad++;
         $display("FAIL %s: dq=%h expected=%h", cur_req, dq, e);
      end
   endtask

   task automatic tick();
      edge_model();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic quiet();
      strb_p_n = 1'b1; strb_c_n = 1'b1; ce_n = 1'b0; adv_n = 1'b1;
      gwr_n = 1'b1; bwe_n = 1'b1; bw_n = 8'hFF; tb_drv = 1'b0; oe_n = 1'b0;
   endtask

   task automatic wr_word(input int a, input logic [DW-1:0] d,
                          input bit gw, input logic [7:0] lanes_n, input bit use_c);
      quiet();
      strb_p_n = use_c; strb_c_n = !use_c;
      addr = AW'(a); tb_dq = d; tb_drv = 1'b1; oe_n = 1'b1;
      gwr_n = !gw; bwe_n = 1'b0; bw_n = lanes_n;
      tick();
   endtask

   task automatic rd_start(input int a, input bit use_c);
      quiet();
      strb_p_n = use_c; strb_c_n = !use_c; addr = AW'(a);
      tick();
   endtask

   task automatic step(input bit adv);
      quiet();
      adv_n = !adv;
      tick();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sleep = 1'b0; burst_mode = 1'b0; addr = '0; tb_dq = '0;
      quiet();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R12";
      compare();              // output register zero after reset
      step(1'b0);             // no burst active: nothing happens
      step(1'b1);

      // R7: global writes fill 0..15, some with stray byte enables
      cur_req = "R7";
      for (int i = 0; i < 16; i++)
         wr_word(i, {32'hA5000000 + i, 32'h0000C300 + 7*i}, 1'b1,
                 (i % 2 == 1) ? 8'h5A : 8'hFF, i % 3 == 0);
      step(1'b0);

      // R1/R2: single reads via both strobes, held cycles repeat the word
      cur_req = "R1";
      for (int i = 0; i < 16; i += 3) begin
         rd_start(i, i % 2 == 1);
         step(1'b0);
      end
      cur_req = "R2";
      rd_start(13, 1'b1);
      rd_start(2, 1'b0);
      step(1'b0);

      // R4: linear from low bits 2: 6,7,4,5 then wrap
      cur_req = "R4";
      burst_mode = 1'b0;
      rd_start(6, 1'b0);
      for (int k = 0; k < 5; k++) step(1'b1);
      step(1'b0);

      // R5: interleaved from low bits 1: 9,8,11,10
      cur_req = "R5";
      burst_mode = 1'b1;
      rd_start(9, 1'b1);
      for (int k = 0; k < 5; k++) step(1'b1);
      step(1'b0);
      rd_start(14, 1'b0);
      for (int k = 0; k < 3; k++) step(1'b1);
      step(1'b0);

      // R3: hold without advance, then mixed advance
      cur_req = "R3";
      burst_mode = 1'b0;
      rd_start(1, 1'b0);
      step(1'b0); step(1'b0); step(1'b1); step(1'b0); step(1'b1); step(1'b1);
      step(1'b0);

      // R6: byte-lane writes, read back on the following held cycle
      cur_req = "R6";
      wr_word(3, 64'h1122334455667788, 1'b0, 8'b1010_0101, 1'b0);
      step(1'b0); step(1'b0);
      wr_word(12, 64'hFFEEDDCCBBAA9988, 1'b0, 8'b0111_1110, 1'b1);
      step(1'b0); step(1'b0);

      // R8: byte gate high with lanes low is a read, memory untouched
      cur_req = "R8";
      quiet(); strb_p_n = 1'b0; addr = AW'(5); bw_n = 8'h00; bwe_n = 1'b1;
      tb_drv = 1'b1; tb_dq = 64'hDEADDEADDEADDEAD; oe_n = 1'b1;
      tick();
      step(1'b0); step(1'b0);
      rd_start(5, 1'b1); step(1'b0);

      // R11: deselect ends burst, advances then do nothing
      cur_req = "R11";
      rd_start(7, 1'b0);
      quiet(); ce_n = 1'b1; strb_c_n = 1'b0; tick();
      step(1'b1); step(1'b1); step(1'b0);
      rd_start(10, 1'b0); step(1'b0);

      // R9: asynchronous output enable and sleep release the bus
      cur_req = "R9";
      quiet();
      #1; oe_n = 1'b1; #1; compare();
      oe_n = 1'b0; #1; compare();
      sleep = 1'b1; #1; compare();
      sleep = 1'b0; #1; compare();

      // R10: writes while asleep and during the wake window are dropped
      cur_req = "R10";
      quiet(); sleep = 1'b1; tick();
      for (int k = 0; k < 2; k++) wr_word(2, 64'h0BADF00D0BADF00D, 1'b1, 8'hFF, 1'b0);
      sleep = 1'b0;
      for (int k = 0; k < WAKE; k++) wr_word(2, 64'h5555AAAA5555AAAA, 1'b1, 8'hFF, 1'b1);
      rd_start(2, 1'b0); step(1'b0); step(1'b0);
      wr_word(2, 64'h0123456789ABCDEF, 1'b1, 8'hFF, 1'b0);
      step(1'b0); step(1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule